// File: doc/BRIEF.md
# ADC Sample and Convert Sequencer

This block is the digital side of a 12-bit successive-approximation converter. Software first enables the block and sets the sample request. The analog input then tracks onto the hold capacitor until a conversion trigger arrives. Four trigger sources are available: software clearing the request, a timer event, an external interrupt, or a self-timed count of conversion periods. After the trigger, the sequencer holds the input and runs twelve comparator decisions from the MSB down. It then commits the code to a result register and pulses a done flag.

Every step is timed in conversion periods. A period lasts `adcs + 1` cycles of the base clock, and the base clock runs at twice the instruction rate, so one period equals TCY × 0.5 × (adcs + 1). If the enable is dropped during a conversion, the conversion is abandoned and the result register keeps its contents. The block then rests for two conversion periods, and during that rest a new sample request is refused.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `result` is 0, and `done`, `conv_busy`, `sh_sample` and `tad_en` are all low.
- R2: While the sequencer is active, `tad_en` pulses for one cycle every `adcs + 1` base clocks, counted from the cycle in which the sequencer enters its current phase.
- R3: With `trig_sel` = 3'b000, a `samp_clr` pulse during sampling starts a conversion. `done` goes high exactly 14 × (`adcs` + 1) cycles after the clock edge that samples `samp_clr`.
- R4: The conversion decides bits MSB first. A high `cmp_in` keeps the trial bit and a low `cmp_in` drops it, so `result` equals the largest code for which the comparator stays high.
- R5: With `trig_sel` = 3'b111, a conversion starts `samc` periods after sampling begins, and a `samc` of 0 counts as 1. When the result is committed, sampling restarts at once, so the next result follows after (`samc` + 14) periods.
- R6: With `trig_sel` = 3'b010, only `tmr_evt` triggers a conversion. With 3'b001, only `ext_irq` does. Codes 3'b011 through 3'b110 never trigger, so sampling simply continues.
- R7: `done` is a one-cycle pulse, raised only at the edge on which a conversion writes `result`.
- R8: When `ctl_on` is sampled low during a conversion, `conv_busy` drops at the next edge. In that case `done` does not pulse and `result` is left unchanged.
- R9: When `ctl_on` is low on the edge where the auto-start count expires, the clear takes precedence and no conversion begins.
- R10: After an abort, the block waits 2 conversion periods. A `samp_set` arriving in that window is ignored. Once the window has passed, `samp_set` starts sampling.
- R11: A `buf_wr_en` pulse loads `buf_wr_data` into `result` at the next edge.
- R12: `sh_sample` is high only while sampling. It is never high together with `conv_busy`, and it falls at the edge after `ctl_on` is seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock, twice the instruction rate |
| rst | input | 1 | Synchronous active-high reset |
| ctl_on | input | 1 | Block enable; dropping it aborts a conversion |
| samp_set | input | 1 | Pulse: request sampling |
| samp_clr | input | 1 | Pulse: software trigger when `trig_sel` is 000 |
| trig_sel | input | 3 | Trigger source: 000 software, 001 interrupt, 010 timer, 111 auto |
| samc | input | 5 | Auto-start sampling length in conversion periods |
| adcs | input | 6 | Conversion period divisor, period = adcs+1 base clocks |
| tmr_evt | input | 1 | Timer trigger event |
| ext_irq | input | 1 | External interrupt trigger |
| cmp_in | input | 1 | Comparator: 1 when the input is at least `sar_code` |
| buf_wr_en | input | 1 | Software write strobe for the result register |
| buf_wr_data | input | 12 | Software write data |
| tad_en | output | 1 | One-cycle conversion clock enable |
| sh_sample | output | 1 | Sample switch closed (acquiring) |
| conv_busy | output | 1 | Conversion in progress |
| sar_code | output | 12 | Current trial code for the DAC |
| result | output | 12 | Result register |
| done | output | 1 | Result written by a conversion |

## Verification
`sh_sample` and `conv_busy` respond one edge after the input that causes them, so the bench checks them at the falling edge that follows. `done` follows a trigger by 14 periods for a timer, interrupt or software trigger. In auto mode it follows by (`samc` + 14) periods, and the bench counts this from the edge on which sampling starts. The monitor records the cycle in which the stimulus edge falls and compares the gap when `done` appears. It also pops the expected code from the queue at that point, and any `done` that arrives with nothing queued counts as a failure. The abort and wait cases are timed against the edge that samples `ctl_on` low; a refused `samp_set` is placed inside the 2-period window, and an accepted one is placed after it.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_CONV   = 2'd2,
        ST_WAIT   = 2'd3
    } seq_state_e;

    typedef enum logic [2:0] {
        TRG_MANUAL = 3'b000,
        TRG_IRQ    = 3'b001,
        TRG_TMR    = 3'b010,
        TRG_AUTO   = 3'b111
    } trig_src_e;

    typedef struct packed {
        logic load;
        logic step;
        logic commit;
    } sar_ctl_t;

    localparam int unsigned HOLD_PERIODS   = 1;
    localparam int unsigned COMMIT_PERIODS = 1;
    localparam int unsigned ABORT_PERIODS  = 2;

    function automatic int unsigned conv_periods(input int unsigned res_w);
        return HOLD_PERIODS + res_w + COMMIT_PERIODS;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_tad_div.sv
module adc_tad_div #(
    parameter int unsigned DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             sync,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run || sync) begin
            cnt_q <= '0;
        end else if (cnt_q == div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == div);
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       sw_clr,
    input  logic       tmr_evt,
    input  logic       ext_irq,
    input  logic       auto_hit,
    output logic       trig
);
    always_comb begin
        unique case (sel)
            TRG_MANUAL: trig = sw_clr;
            TRG_IRQ:    trig = ext_irq;
            TRG_TMR:    trig = tmr_evt;
            TRG_AUTO:   trig = auto_hit;
            default:    trig = 1'b0;
        endcase
    end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  sar_ctl_t         ctl,
    input  logic             cmp,
    output logic [RES_W-1:0] code
);
    localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] code_q;
    logic [RES_W-1:0] mask_q;
    logic [RES_W-1:0] code_nxt;

    always_comb begin
        code_nxt = (cmp ? code_q : (code_q & ~mask_q)) | (mask_q >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mask_q <= '0;
        end else if (ctl.load) begin
            code_q <= MSB_ONE;
            mask_q <= MSB_ONE;
        end else if (ctl.step) begin
            code_q <= code_nxt;
            mask_q <= mask_q >> 1;
        end
    end

    assign code = code_q;
endmodule

// File: rtl/adc_result_buf.sv
module adc_result_buf #(
    parameter int unsigned RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_wr,
    input  logic [RES_W-1:0] conv_data,
    input  logic             sw_wr,
    input  logic [RES_W-1:0] sw_data,
    output logic [RES_W-1:0] result,
    output logic             done
);
    logic [RES_W-1:0] res_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= conv_wr;
            if (conv_wr) begin
                res_q <= conv_data;
            end else if (sw_wr) begin
                res_q <= sw_data;
            end
        end
    end

    assign result = res_q;
    assign done   = done_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int unsigned RES_W  = 12,
    parameter int unsigned DIV_W  = 6,
    parameter int unsigned SAMC_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_on,
    input  logic              samp_set,
    input  logic              samp_clr,
    input  logic [2:0]        trig_sel,
    input  logic [SAMC_W-1:0] samc,
    input  logic [DIV_W-1:0]  adcs,
    input  logic              tmr_evt,
    input  logic              ext_irq,
    input  logic              cmp_in,
    input  logic              buf_wr_en,
    input  logic [RES_W-1:0]  buf_wr_data,
    output logic              tad_en,
    output logic              sh_sample,
    output logic              conv_busy,
    output logic [RES_W-1:0]  sar_code,
    output logic [RES_W-1:0]  result,
    output logic              done
);
    localparam int unsigned CONV_PER = conv_periods(RES_W);
    localparam int unsigned PH_W     = max_u(SAMC_W, $clog2(CONV_PER + 1)) + 1;

    localparam logic [PH_W-1:0] PH_LAST_CONV = PH_W'(CONV_PER - 1);
    localparam logic [PH_W-1:0] PH_LAST_BIT  = PH_W'(HOLD_PERIODS + RES_W - 1);
    localparam logic [PH_W-1:0] PH_FIRST_BIT = PH_W'(HOLD_PERIODS);
    localparam logic [PH_W-1:0] PH_LAST_WAIT = PH_W'(ABORT_PERIODS - 1);

    seq_state_e       state_q, state_d;
    logic [PH_W-1:0]  ph_q;
    logic [PH_W-1:0]  samc_eff;
    logic             tick;
    logic             sync;
    logic             auto_hit;
    logic             trig;
    logic             is_auto;
    sar_ctl_t         sar_ctl;

    assign is_auto  = (trig_sel == TRG_AUTO);
    assign samc_eff = (samc == '0) ? PH_W'(1) : PH_W'(samc);
    assign auto_hit = (state_q == ST_SAMPLE) && tick && ((ph_q + 1'b1) >= samc_eff);

    adc_trig_sel u_trig (
        .sel      (trig_sel),
        .sw_clr   (samp_clr),
        .tmr_evt  (tmr_evt),
        .ext_irq  (ext_irq),
        .auto_hit (auto_hit),
        .trig     (trig)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_on && samp_set) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (!ctl_on)   state_d = ST_IDLE;
                else if (trig) state_d = ST_CONV;
            end
            ST_CONV: begin
                if (!ctl_on) begin
                    state_d = ST_WAIT;
                end else if (tick && ph_q == PH_LAST_CONV) begin
                    state_d = is_auto ? ST_SAMPLE : ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (tick && ph_q == PH_LAST_WAIT) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign sync = (state_d != state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
        end else begin
            state_q <= state_d;
            if (sync)      ph_q <= '0;
            else if (tick) ph_q <= ph_q + 1'b1;
        end
    end

    adc_tad_div #(.DIV_W(DIV_W)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state_q != ST_IDLE),
        .sync (sync),
        .div  (adcs),
        .tick (tick)
    );

    always_comb begin
        sar_ctl.load   = (state_q != ST_CONV) && (state_d == ST_CONV);
        sar_ctl.step   = (state_q == ST_CONV) && ctl_on && tick &&
                         (ph_q >= PH_FIRST_BIT) && (ph_q <= PH_LAST_BIT);
        sar_ctl.commit = (state_q == ST_CONV) && ctl_on && tick && (ph_q == PH_LAST_CONV);
    end

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk  (clk),
        .rst  (rst),
        .ctl  (sar_ctl),
        .cmp  (cmp_in),
        .code (sar_code)
    );

    adc_result_buf #(.RES_W(RES_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .conv_wr   (sar_ctl.commit),
        .conv_data (sar_code),
        .sw_wr     (buf_wr_en),
        .sw_data   (buf_wr_data),
        .result    (result),
        .done      (done)
    );

    assign tad_en    = tick;
    assign sh_sample = (state_q == ST_SAMPLE);
    assign conv_busy = (state_q == ST_CONV);
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int unsigned RES_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             ctl_on,
    input logic             buf_wr_en,
    input logic             sh_sample,
    input logic             conv_busy,
    input logic [RES_W-1:0] result,
    input logic             done
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_from_conv: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(conv_busy));

    a_r8_off_stops_conv: assert property (@(posedge clk) disable iff (rst)
        !ctl_on |=> !conv_busy);

    a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(buf_wr_en)) |-> $stable(result));

    a_r12_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(sh_sample && conv_busy));

    a_r12_off_ends_sample: assert property (@(posedge clk) disable iff (rst)
        !ctl_on |=> !sh_sample);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctl_on    (ctl_on),
    .buf_wr_en (buf_wr_en),
    .sh_sample (sh_sample),
    .conv_busy (conv_busy),
    .result    (result),
    .done      (done)
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_on = 1'b0, samp_set = 1'b0, samp_clr = 1'b0;
    logic [2:0]  trig_sel = 3'b000;
    logic [4:0]  samc = 5'd1;
    logic [5:0]  adcs = 6'd3;
    logic        tmr_evt = 1'b0, ext_irq = 1'b0;
    logic        cmp_in;
    logic        buf_wr_en = 1'b0;
    logic [11:0] buf_wr_data = '0;
    logic        tad_en, sh_sample, conv_busy, done;
    logic [11:0] sar_code, result;
    logic [11:0] vin = '0;

    int total = 0, bad = 0;
    int cyc = 0, t0 = 0, exp_lat = 0;
    bit lat_armed = 0, lat_rearm = 0, finished = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cmp_in = (vin >= sar_code);

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst(rst), .ctl_on(ctl_on), .samp_set(samp_set), .samp_clr(samp_clr),
        .trig_sel(trig_sel), .samc(samc), .adcs(adcs), .tmr_evt(tmr_evt), .ext_irq(ext_irq),
        .cmp_in(cmp_in), .buf_wr_en(buf_wr_en), .buf_wr_data(buf_wr_data),
        .tad_en(tad_en), .sh_sample(sh_sample), .conv_busy(conv_busy),
        .sar_code(sar_code), .result(result), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // monitor: pops expected results as done appears
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 R8 unexpected done", int'(result), -1);
            end else begin
                int e;
                e = exp_q.pop_front();
                chk(result == 12'(e), "R4 converted code", int'(result), e);
            end
            if (lat_armed) begin
                chk(cyc - t0 == exp_lat, "R3 R5 done latency", cyc - t0, exp_lat);
                if (lat_rearm) t0 = cyc;
                else lat_armed = 0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired R1", 0, 1);
        summary();
    end

    task automatic tick_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_samp_set();
        @(negedge clk) samp_set = 1'b1;
        @(negedge clk) samp_set = 1'b0;
    endtask

    task automatic wait_queue_empty();
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() == 0) break;
        end
    endtask

    task automatic manual_conv(input logic [11:0] v, input int p);
        vin = v;
        exp_q.push_back(int'(v));
        pulse_samp_set();
        tick_n(3);
        @(negedge clk) samp_clr = 1'b1;
        @(negedge clk) samp_clr = 1'b0;
        t0 = cyc; exp_lat = 14 * p; lat_armed = 1;
        wait_queue_empty();
    endtask

    initial begin
        tick_n(4);
        @(negedge clk) rst = 1'b0;
        // R1 reset state
        chk(result == 0 && !done && !conv_busy && !sh_sample && !tad_en,
            "R1 reset outputs", int'(result), 0);

        // R2 period count in sampling, R12 sampling flag
        ctl_on = 1'b1; trig_sel = 3'b000; adcs = 6'd3;
        pulse_samp_set();
        begin
            int n = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (tad_en) n++;
            end
            chk(n == 10, "R2 tad pulses in 40 cycles", n, 10);
        end
        chk(sh_sample && !conv_busy, "R12 sampling flag", int'(sh_sample), 1);
        ctl_on = 1'b0; tick_n(2); ctl_on = 1'b1;

        // R3 R4 manual conversions
        manual_conv(12'hA5C, 4);
        chk(!sh_sample && !conv_busy, "R3 idle after manual conversion", int'(sh_sample), 0);
        adcs = 6'd0;
        manual_conv(12'hFFF, 1);
        manual_conv(12'h000, 1);
        manual_conv(12'h001, 1);

        // R11 software write
        @(negedge clk) begin buf_wr_en = 1'b1; buf_wr_data = 12'h123; end
        @(negedge clk) buf_wr_en = 1'b0;
        chk(result == 12'h123, "R11 software write", int'(result), 12'h123);

        // R6 timer source ignores interrupt
        adcs = 6'd1; trig_sel = 3'b010; vin = 12'h3C7;
        pulse_samp_set(); tick_n(4);
        @(negedge clk) ext_irq = 1'b1;
        @(negedge clk) ext_irq = 1'b0;
        tick_n(1);
        chk(sh_sample && !conv_busy, "R6 interrupt ignored in timer mode", int'(conv_busy), 0);
        exp_q.push_back(12'h3C7);
        @(negedge clk) tmr_evt = 1'b1;
        @(negedge clk) tmr_evt = 1'b0;
        t0 = cyc; exp_lat = 28; lat_armed = 1;
        wait_queue_empty();

        // R6 interrupt source
        trig_sel = 3'b001; vin = 12'h801;
        pulse_samp_set(); tick_n(3);
        exp_q.push_back(12'h801);
        @(negedge clk) ext_irq = 1'b1;
        @(negedge clk) ext_irq = 1'b0;
        t0 = cyc; exp_lat = 28; lat_armed = 1;
        wait_queue_empty();

        // R6 unused code never triggers
        trig_sel = 3'b011;
        pulse_samp_set();
        @(negedge clk) begin tmr_evt = 1'b1; ext_irq = 1'b1; samp_clr = 1'b1; end
        @(negedge clk) begin tmr_evt = 1'b0; ext_irq = 1'b0; samp_clr = 1'b0; end
        tick_n(3);
        chk(sh_sample && !conv_busy, "R6 unused code stays sampling", int'(conv_busy), 0);
        @(negedge clk) ctl_on = 1'b0;
        @(negedge clk) chk(!sh_sample, "R12 sampling ends on disable", int'(sh_sample), 0);
        ctl_on = 1'b1;

        // R5 auto mode, two back to back conversions
        trig_sel = 3'b111; samc = 5'd3; adcs = 6'd1; vin = 12'h5A5;
        exp_q.push_back(12'h5A5); exp_q.push_back(12'h5A5);
        lat_rearm = 1;
        pulse_samp_set();
        t0 = cyc; exp_lat = (3 + 14) * 2; lat_armed = 1;
        wait_queue_empty();
        ctl_on = 1'b0; lat_armed = 0; lat_rearm = 0;
        chk(sh_sample, "R5 sampling restarts after commit", int'(sh_sample), 1);
        tick_n(2); ctl_on = 1'b1;

        // R5 samc zero counts as one
        samc = 5'd0; vin = 12'h0F0;
        exp_q.push_back(12'h0F0);
        pulse_samp_set();
        t0 = cyc; exp_lat = (1 + 14) * 2; lat_armed = 1;
        wait_queue_empty();
        ctl_on = 1'b0; lat_armed = 0;
        tick_n(2); ctl_on = 1'b1;

        // R9 disable on the auto-start edge
        samc = 5'd2; adcs = 6'd1;
        pulse_samp_set();
        tick_n(2);
        @(negedge clk) ctl_on = 1'b0;
        @(negedge clk) chk(!conv_busy, "R9 disable beats auto-start", int'(conv_busy), 0);
        tick_n(30);
        chk(result == 12'h0F0, "R9 result untouched", int'(result), 12'h0F0);
        ctl_on = 1'b1;

        // R8 R10 abort, hold-off window
        trig_sel = 3'b000; adcs = 6'd3; vin = 12'h777;
        pulse_samp_set(); tick_n(2);
        @(negedge clk) samp_clr = 1'b1;
        @(negedge clk) samp_clr = 1'b0;
        tick_n(20);
        chk(conv_busy, "R8 conversion running before abort", int'(conv_busy), 1);
        @(negedge clk) ctl_on = 1'b0;
        @(negedge clk) begin
            chk(!conv_busy, "R8 busy drops after abort", int'(conv_busy), 0);
            ctl_on = 1'b1;
        end
        pulse_samp_set();
        chk(!sh_sample, "R10 sample request refused in wait", int'(sh_sample), 0);
        tick_n(8);
        chk(result == 12'h0F0, "R8 result kept after abort", int'(result), 12'h0F0);
        pulse_samp_set();
        chk(sh_sample, "R10 sample accepted after wait", int'(sh_sample), 1);
        @(negedge clk) ctl_on = 1'b0;
        tick_n(4);
        chk(exp_q.size() == 0, "R7 no pending results", exp_q.size(), 0);
        summary();
    end
endmodule